// File: doc/BRIEF.md
# Conditional Program-Counter Redirect Unit

This block works out the next 16-bit program counter for conditional control-transfer instructions. The execution pipeline gives it the opcode byte and the current counter. The current counter is the address of the first byte after the opcode. The pipeline also gives the two bytes fetched from that address onward, plus the processor status: D-is-zero, the carry flag DF, the Q output, interrupt enable, and four external flag lines. One clock later the block returns the new counter and a flag. The flag says whether the fetched bytes were loaded into the counter.

Three instruction groups are handled.

- **Short branches** (high nibble 3) can replace only the low byte of the counter.
- **Long branches** (high nibble C, low nibble 0-3 and 8-B) can replace both bytes.
- **Long skips** (high nibble C, low nibble 5-7 and C-F) can step the counter forward by two.

Opcode C4 is a no-operation. Any other opcode leaves the counter unchanged, so the pipeline may present every instruction without filtering. Memory fetch and bus timing belong to the surrounding core.

Top module: `pcu_top`

## Requirements
- R1: For opcodes 0x30-0x3F with the condition true, `pc_next` = {`pc_cur`[15:8], `opnd0`}. The high byte is kept and `opnd_used` = 1.
- R2: For opcodes 0x30-0x3F with the condition false, `pc_next` = `pc_cur` + 1 and `opnd_used` = 0.
- R3: For long-branch opcodes (0xC0-0xC3, 0xC8-0xCB) with the condition true, `pc_next` = {`opnd0`, `opnd1`} and `opnd_used` = 1.
- R4: For long-branch opcodes with the condition false, `pc_next` = `pc_cur` + 2 and `opnd_used` = 0.
- R5: For long-skip opcodes (0xC5-0xC7, 0xCC-0xCF), a true condition gives `pc_next` = `pc_cur` + 2 and a false condition gives `pc_next` = `pc_cur`. In both cases `opnd_used` = 0.
- R6: Short-branch conditions are selected by opcode bits [2:0]:
  - 0: always
  - 1: Q = 1
  - 2: D-is-zero = 1
  - 3: DF = 1
  - 4-7: `ext_flags`[0]-[3] = 1

  Opcode bit 3 = 1 inverts the result.
- R7: Long-branch conditions use bits [1:0] with the meanings of codes 0-3 in R6. Bit 3 inverts, so 0xC8 never branches. Opcode 0xC4 is a no-operation: `pc_next` = `pc_cur` and `opnd_used` = 0.
- R8: Skip conditions are as follows:
  - 0xC5: Q = 0
  - 0xC6: D-is-zero = 0
  - 0xC7: DF = 0
  - 0xCC: interrupt enable = 1
  - 0xCD: Q = 1
  - 0xCE: D-is-zero = 1
  - 0xCF: DF = 1
- R9: Any opcode outside 0x30-0x3F and 0xC0-0xCF gives `pc_next` = `pc_cur` and `opnd_used` = 0.
- R10: Results appear one clock after the inputs are sampled. `out_valid` copies `in_valid` with one cycle of delay, and `opnd_used` is 1 only while `out_valid` is 1.
- R11: While `rst_n` is low on a clock edge, the outputs are cleared: `out_valid` = 0, `pc_next` = 0, `opnd_used` = 0.
- R12: Counter arithmetic wraps modulo 2^16.
  - A short branch taken at 0x12FF keeps the high byte 0x12.
  - A short branch not taken at 0x12FF moves to 0x1300.
  - A long branch not taken at 0xFFFF gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs below hold an instruction to evaluate |
| opcode | input | 8 | Instruction opcode byte |
| pc_cur | input | 16 | Counter value, pointing at the first operand byte |
| opnd0 | input | 8 | Byte at `pc_cur` |
| opnd1 | input | 8 | Byte at `pc_cur` + 1 |
| d_is_zero | input | 1 | Accumulator equals zero |
| df_flag | input | 1 | Carry/borrow flag |
| q_flag | input | 1 | Q output flip-flop state |
| ie_flag | input | 1 | Interrupt enable |
| ext_flags | input | 4 | External flag lines 1-4 (bit 0 is line 1) |
| out_valid | output | 1 | `pc_next` and `opnd_used` are valid |
| pc_next | output | 16 | Updated program counter |
| opnd_used | output | 1 | Fetched operand bytes were loaded into the counter |

## Verification
Every result is due exactly one clock edge after its inputs are sampled. The bench drives inputs on a falling edge and lets one rising edge pass. It then reads `pc_next`, `opnd_used` and `out_valid` at the following falling edge, before the next instruction can change them. Drop of `out_valid` is checked one edge after `in_valid` is cleared. The reset values are read while reset is held across an edge.

// File: rtl/pcu_pkg.sv
// Package: shared types for the program-counter redirect unit.
// Assumes opcodes are 8 bits; groups are decided by the high nibble.
package pcu_pkg;

    typedef enum logic [2:0] {
        CT_NONE  = 3'd0,
        CT_SHORT = 3'd1,
        CT_LONG  = 3'd2,
        CT_SKIP  = 3'd3,
        CT_NOP   = 3'd4
    } ctl_kind_t;

    // Condition source index: 0 always, 1 Q, 2 D==0, 3 DF, 4..7 ext flags, 8 IE
    localparam int COND_SEL_W = 4;
    localparam int COND_N     = 9;

    typedef struct packed {
        ctl_kind_t               kind;
        logic [COND_SEL_W-1:0]   sel;
        logic                    invert;
    } ctl_decode_t;

endpackage

// File: rtl/pcu_decode.sv
// Module: pcu_decode
// Classifies an opcode into a control-transfer kind, a condition source
// and a polarity. Purely combinational; assumes an 8-bit opcode.
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [7:0]  opcode,
    output ctl_decode_t dec
);

    logic [3:0] hi_nib;
    logic [3:0] lo_nib;

    assign hi_nib = opcode[7:4];
    assign lo_nib = opcode[3:0];

    // Map the opcode onto kind, condition source and sense.
    always_comb begin
        dec.kind   = CT_NONE;
        dec.sel    = '0;
        dec.invert = 1'b0;
        if (hi_nib == 4'h3) begin
            dec.kind   = CT_SHORT;
            dec.sel    = {1'b0, lo_nib[2:0]};
            dec.invert = lo_nib[3];
        end else if (hi_nib == 4'hC) begin
            if (lo_nib == 4'h4) begin
                dec.kind = CT_NOP;
            end else if (lo_nib[2] == 1'b0) begin
                dec.kind   = CT_LONG;
                dec.sel    = {2'b00, lo_nib[1:0]};
                dec.invert = lo_nib[3];
            end else begin
                dec.kind   = CT_SKIP;
                dec.sel    = (lo_nib[1:0] == 2'b00) ? 4'd8 : {2'b00, lo_nib[1:0]};
                dec.invert = ~lo_nib[3];
            end
        end
    end

endmodule

// File: rtl/pcu_cond.sv
// Module: pcu_cond
// Evaluates the selected status condition and applies its polarity.
// Assumes FLAG_N external flag lines occupy source indices 4 upward.
module pcu_cond
    import pcu_pkg::*;
#(
    parameter int FLAG_N = 4
) (
    input  logic [COND_SEL_W-1:0] sel,
    input  logic                  invert,
    input  logic                  d_is_zero,
    input  logic                  df_flag,
    input  logic                  q_flag,
    input  logic                  ie_flag,
    input  logic [FLAG_N-1:0]     ext_flags,
    output logic                  cond_true
);

    localparam int EXT_BASE = 4;
    localparam int SRC_N    = (EXT_BASE + FLAG_N > COND_N) ? EXT_BASE + FLAG_N + 1 : COND_N;
    localparam int IE_IDX   = SRC_N - 1;

    logic [SRC_N-1:0] src;

    assign src[0] = 1'b1;
    assign src[1] = q_flag;
    assign src[2] = d_is_zero;
    assign src[3] = df_flag;

    // Place each external flag line on its own source slot.
    for (genvar g = 0; g < FLAG_N; g++) begin : g_ext
        assign src[EXT_BASE + g] = ext_flags[g];
    end

    // Fill unused slots between the flags and the IE slot.
    for (genvar u = EXT_BASE + FLAG_N; u < IE_IDX; u++) begin : g_pad
        assign src[u] = 1'b0;
    end

    assign src[IE_IDX] = ie_flag;

    // Pick the source (index 8 means IE) and apply polarity.
    always_comb begin
        logic raw;
        if (sel == 4'd8)
            raw = src[IE_IDX];
        else if (int'(sel) < IE_IDX)
            raw = src[sel];
        else
            raw = 1'b0;
        cond_true = raw ^ invert;
    end

endmodule

// File: rtl/pcu_next.sv
// Module: pcu_next
// Forms the next counter from the kind, the condition and the operands.
// Assumes PC_W is twice BYTE_W; all sums wrap at PC_W bits.
module pcu_next
    import pcu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PC_W   = 2 * BYTE_W
) (
    input  ctl_kind_t           kind,
    input  logic                cond_true,
    input  logic [PC_W-1:0]     pc_cur,
    input  logic [BYTE_W-1:0]   opnd0,
    input  logic [BYTE_W-1:0]   opnd1,
    output logic [PC_W-1:0]     pc_new,
    output logic                used
);

    logic [PC_W-1:0] pc_plus1;
    logic [PC_W-1:0] pc_plus2;

    assign pc_plus1 = pc_cur + PC_W'(1);
    assign pc_plus2 = pc_cur + PC_W'(2);

    // Select the counter update for each instruction group.
    always_comb begin
        pc_new = pc_cur;
        used   = 1'b0;
        unique case (kind)
            CT_SHORT: begin
                pc_new = cond_true ? {pc_cur[PC_W-1:BYTE_W], opnd0} : pc_plus1;
                used   = cond_true;
            end
            CT_LONG: begin
                pc_new = cond_true ? {opnd0, opnd1} : pc_plus2;
                used   = cond_true;
            end
            CT_SKIP: begin
                pc_new = cond_true ? pc_plus2 : pc_cur;
            end
            CT_NOP, CT_NONE: begin
                pc_new = pc_cur;
            end
            default: begin
                pc_new = pc_cur;
            end
        endcase
    end

endmodule

// File: rtl/pcu_top.sv
// Module: pcu_top
// Program-counter redirect unit for short branches, long branches and
// long skips. One register stage: results appear one clock after inputs.
// Assumes operand bytes were fetched from pc_cur and pc_cur+1 before use.
module pcu_top
    import pcu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PC_W   = 16,
    parameter int FLAG_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [BYTE_W-1:0] opnd0,
    input  logic [BYTE_W-1:0] opnd1,
    input  logic              d_is_zero,
    input  logic              df_flag,
    input  logic              q_flag,
    input  logic              ie_flag,
    input  logic [FLAG_N-1:0] ext_flags,
    output logic              out_valid,
    output logic [PC_W-1:0]   pc_next,
    output logic              opnd_used
);

    ctl_decode_t     dec;
    logic            cond_true;
    logic [PC_W-1:0] pc_comb;
    logic            used_comb;

    pcu_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    pcu_cond #(.FLAG_N(FLAG_N)) u_cond (
        .sel       (dec.sel),
        .invert    (dec.invert),
        .d_is_zero (d_is_zero),
        .df_flag   (df_flag),
        .q_flag    (q_flag),
        .ie_flag   (ie_flag),
        .ext_flags (ext_flags),
        .cond_true (cond_true)
    );

    pcu_next #(.BYTE_W(BYTE_W), .PC_W(PC_W)) u_next (
        .kind      (dec.kind),
        .cond_true (cond_true),
        .pc_cur    (pc_cur),
        .opnd0     (opnd0),
        .opnd1     (opnd1),
        .pc_new    (pc_comb),
        .used      (used_comb)
    );

    // Register the result; synchronous active-low reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pc_next   <= '0;
            opnd_used <= 1'b0;
        end else begin
            out_valid <= in_valid;
            pc_next   <= pc_comb;
            opnd_used <= in_valid & used_comb;
        end
    end

endmodule

// File: rtl/pcu_checker.sv
// Module: pcu_checker
// Protocol and behaviour properties for pcu_top, attached by bind.
module pcu_checker #(
    parameter int BYTE_W = 8,
    parameter int PC_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        opcode,
    input logic [PC_W-1:0]   pc_cur,
    input logic              out_valid,
    input logic [PC_W-1:0]   pc_next,
    input logic              opnd_used
);

    // R10
    used_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_used |-> out_valid);

    // R10
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    short_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] == 4'h3)
        |=> pc_next[PC_W-1:BYTE_W] == $past(pc_cur[PC_W-1:BYTE_W])
            || pc_next == $past(pc_cur) + PC_W'(1));

    // R7
    nop_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'hC4) |=> (pc_next == $past(pc_cur) && !opnd_used));

    // R7
    never_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'hC8) |=> (pc_next == $past(pc_cur) + PC_W'(2)));

    // R5
    skip_no_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] == 4'hC && opcode[2] == 1'b1) |=> !opnd_used);

    // R9
    other_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] != 4'h3 && opcode[7:4] != 4'hC)
        |=> (pc_next == $past(pc_cur) && !opnd_used));

endmodule

bind pcu_top pcu_checker #(.BYTE_W(BYTE_W), .PC_W(PC_W)) u_pcu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .pc_cur    (pc_cur),
    .out_valid (out_valid),
    .pc_next   (pc_next),
    .opnd_used (opnd_used)
);

// File: tb/pcu_top_bench.sv
// Bench: pcu_top_bench
// Directed tests, one task per scenario, each checking its own results.
module pcu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  opcode;
    logic [15:0] pc_cur;
    logic [7:0]  opnd0;
    logic [7:0]  opnd1;
    logic        d_is_zero;
    logic        df_flag;
    logic        q_flag;
    logic        ie_flag;
    logic [3:0]  ext_flags;
    logic        out_valid;
    logic [15:0] pc_next;
    logic        opnd_used;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pcu_top u_pcu_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .pc_cur    (pc_cur),
        .opnd0     (opnd0),
        .opnd1     (opnd1),
        .d_is_zero (d_is_zero),
        .df_flag   (df_flag),
        .q_flag    (q_flag),
        .ie_flag   (ie_flag),
        .ext_flags (ext_flags),
        .out_valid (out_valid),
        .pc_next   (pc_next),
        .opnd_used (opnd_used)
    );

    // Reference: returns {used, pc} written per opcode from the requirements.
    function automatic logic [16:0] ref_model(input logic [7:0] op, input logic [15:0] pc,
                                              input logic [7:0] b0, input logic [7:0] b1,
                                              input logic dz, input logic df, input logic q,
                                              input logic ie, input logic [3:0] ef);
        logic c;
        if (op[7:4] == 4'h3) begin
            case (op[2:0])
                3'd0: c = 1'b1;
                3'd1: c = q;
                3'd2: c = dz;
                3'd3: c = df;
                default: c = ef[op[2:0] - 3'd4];
            endcase
            if (op[3]) c = !c;
            return c ? {1'b1, pc[15:8], b0} : {1'b0, pc + 16'd1};
        end
        if (op[7:4] == 4'hC) begin
            case (op[3:0])
                4'h0: c = 1'b1;
                4'h1: c = q;
                4'h2: c = dz;
                4'h3: c = df;
                4'h8: c = 1'b0;
                4'h9: c = !q;
                4'hA: c = !dz;
                4'hB: c = !df;
                default: c = 1'b0;
            endcase
            case (op[3:0])
                4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB:
                    return c ? {1'b1, b0, b1} : {1'b0, pc + 16'd2};
                4'h5: return {1'b0, !q  ? pc + 16'd2 : pc};
                4'h6: return {1'b0, !dz ? pc + 16'd2 : pc};
                4'h7: return {1'b0, !df ? pc + 16'd2 : pc};
                4'hC: return {1'b0, ie  ? pc + 16'd2 : pc};
                4'hD: return {1'b0, q   ? pc + 16'd2 : pc};
                4'hE: return {1'b0, dz  ? pc + 16'd2 : pc};
                4'hF: return {1'b0, df  ? pc + 16'd2 : pc};
                default: return {1'b0, pc};
            endcase
        end
        return {1'b0, pc};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge; read the result one edge later.
    task automatic run_one(input string req, input logic [7:0] op, input logic [15:0] pc,
                           input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] fl);
        logic [16:0] exp;
        in_valid  = 1'b1;
        opcode    = op;
        pc_cur    = pc;
        opnd0     = b0;
        opnd1     = b1;
        d_is_zero = fl[0];
        df_flag   = fl[1];
        q_flag    = fl[2];
        ie_flag   = fl[3];
        ext_flags = fl[7:4];
        exp = ref_model(op, pc, b0, b1, fl[0], fl[1], fl[2], fl[3], fl[7:4]);
        @(negedge clk);
        check(req, {15'd0, out_valid, opnd_used, pc_next}, {15'd0, 1'b1, exp});
    endtask

    // R11: outputs cleared while reset is held across an edge.
    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; opcode = 8'h30; pc_cur = 16'h1234; opnd0 = 8'h55; opnd1 = 8'h66;
        d_is_zero = 1'b1; df_flag = 1'b1; q_flag = 1'b1; ie_flag = 1'b1; ext_flags = 4'hF;
        repeat (2) @(negedge clk);
        check("R11 reset", {15'd0, out_valid, opnd_used, pc_next}, 32'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // R1 R2 R6: every short-branch opcode under a spread of flag patterns.
    task automatic t_short_sweep();
        for (int op = 8'h30; op <= 8'h3F; op++) begin
            for (int k = 0; k < 16; k++) begin
                run_one("R1/R2/R6 short", 8'(op), 16'h4A10 + 16'(k), 8'(8'hA0 + k), 8'h5C,
                        {4'(k * 5), 4'(k)});
            end
        end
    endtask

    // R3 R4 R5 R7 R8: every 0xC0-0xCF opcode under a spread of flag patterns.
    task automatic t_long_sweep();
        for (int op = 8'hC0; op <= 8'hCF; op++) begin
            for (int k = 0; k < 16; k++) begin
                run_one("R3/R4/R5/R7/R8 long", 8'(op), 16'h7700 + 16'(k * 3), 8'hBE, 8'(k + 8'h20),
                        {4'(k * 7), 4'(k)});
            end
        end
    endtask

    // Directed single cases with hand-computed values.
    task automatic t_directed();
        // R1: BR at 0x5678 taken -> 0x56EE
        run_one("R1 br", 8'h30, 16'h5678, 8'hEE, 8'h00, 8'h00);
        check("R1 br value", {16'd0, pc_next}, 32'h0000_56EE);
        // R2: NBR -> pc+1
        run_one("R2 nbr", 8'h38, 16'h5678, 8'hEE, 8'h00, 8'h00);
        check("R2 nbr value", {16'd0, pc_next}, 32'h0000_5679);
        // R6: flag line 3 (bit 2) set, opcode 0x36 taken
        run_one("R6 ef3", 8'h36, 16'h0100, 8'h42, 8'h00, 8'h40);
        check("R6 ef3 value", {15'd0, opnd_used, pc_next}, {15'd0, 1'b1, 16'h0142});
        // R3: LBR
        run_one("R3 lbr", 8'hC0, 16'h0200, 8'hAB, 8'hCD, 8'h00);
        check("R3 lbr value", {15'd0, opnd_used, pc_next}, {15'd0, 1'b1, 16'hABCD});
        // R7: NOP leaves pc alone
        run_one("R7 nop", 8'hC4, 16'h0200, 8'hAB, 8'hCD, 8'hFF);
        check("R7 nop value", {15'd0, opnd_used, pc_next}, {15'd0, 1'b0, 16'h0200});
        // R8: skip on IE set / clear
        run_one("R8 ie", 8'hCC, 16'h0300, 8'h00, 8'h00, 8'h08);
        check("R8 ie value", {16'd0, pc_next}, 32'h0000_0302);
        run_one("R8 no ie", 8'hCC, 16'h0300, 8'h00, 8'h00, 8'hF7);
        check("R8 no ie value", {16'd0, pc_next}, 32'h0000_0300);
        // R12: page and top-of-memory wrap
        run_one("R12 short taken", 8'h30, 16'h12FF, 8'h05, 8'h00, 8'h00);
        check("R12 short taken value", {16'd0, pc_next}, 32'h0000_1205);
        run_one("R12 short not taken", 8'h38, 16'h12FF, 8'h05, 8'h00, 8'h00);
        check("R12 short not taken value", {16'd0, pc_next}, 32'h0000_1300);
        run_one("R12 long wrap", 8'hC8, 16'hFFFF, 8'h05, 8'h06, 8'h00);
        check("R12 long wrap value", {16'd0, pc_next}, 32'h0000_0001);
        // R4: LBNZ with D zero -> +2
        run_one("R4 lbnz", 8'hCA, 16'h8000, 8'h11, 8'h22, 8'h01);
        check("R4 lbnz value", {15'd0, opnd_used, pc_next}, {15'd0, 1'b0, 16'h8002});
    endtask

    // R9: opcodes outside both groups leave pc unchanged.
    task automatic t_others();
        for (int op = 0; op < 256; op += 7) begin
            if (op[7:4] != 4'h3 && op[7:4] != 4'hC) begin
                run_one("R9 other", 8'(op), 16'h3C3C, 8'hFF, 8'hFF, 8'hFF);
                check("R9 other value", {15'd0, opnd_used, pc_next}, {15'd0, 1'b0, 16'h3C3C});
            end
        end
    endtask

    // R10: out_valid follows in_valid with one cycle of delay.
    task automatic t_valid();
        run_one("R10 valid", 8'h30, 16'h0000, 8'h10, 8'h00, 8'h00);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 valid drop", {30'd0, out_valid, opnd_used}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_short_sweep();
        t_long_sweep();
        t_directed();
        t_others();
        t_valid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule